// File: doc/BRIEF.md
# Cascaded FIFO Depth Token Controller

This block lets several identical FIFO devices be chained into one deeper queue. Each device runs one copy. The devices pass two tokens around a ring. The write token says which device takes the next word. The read token says which device delivers the next word. The block keeps the local write and read positions and the local fill count. It tells the neighbouring storage core which address to use and whether a request is granted. When a device accepts a write or read at its last location, it gives the matching token up and announces the hand-off on an active-low expansion output. That output is wired to the expansion input of the next device in the ring.

The operating mode is captured while reset is held. If the expansion input is low during reset, the device works alone (single-device mode). It then holds both tokens for good, the expansion output reports the half-full state (active low), and the strap input works as a retransmit control. If the expansion input is high during reset, the device is part of a chain (depth mode). In that case the strap input, sampled during reset, marks the one device that starts with both tokens.

Top module: `fifo_chain_ctrl`

## Requirements
- R1: While `rstN` is low, `expInN` is sampled. Low selects single-device mode (`singleMode`=1, both tokens reported held). High selects depth mode (`singleMode`=0).
- R2: In depth mode, the device whose `flRtN` was low during reset holds both tokens after reset. A device whose `flRtN` was high holds neither token.
- R3: A write is granted only when the device holds the write token and its count is below DEPTH, or when a read is granted in the same cycle. A read is granted only when the device holds the read token and its count is above zero.
- R4: In depth mode, an accepted write at `wrAddr`=DEPTH-1 releases the write token and wraps `wrAddr` to 0. `expOutN` is then low for exactly the next cycle. An accepted read at `rdAddr`=DEPTH-1 does the same for the read token.
- R5: In depth mode, each clock cycle in which `expInN` is low grants one token. After reset, the first such cycle grants the write token, and the grants then alternate between write and read.
- R6: If a write hand-off and a read hand-off are accepted in the same cycle, `expOutN` is low for two consecutive cycles. The write hand-off takes the first cycle and the read hand-off the second.
- R7: In single-device mode, `expOutN` is low exactly when the count is greater than DEPTH/2.
- R8: In single-device mode, `flRtN` low sets `rdAddr` to 0, leaves `wrAddr` unchanged, sets the count to the number of writes since reset (at most DEPTH), and refuses both requests in that cycle.
- R9: In depth mode, `flRtN` has no effect after reset.
- R10: `wrAddr` and `rdAddr` each advance by one per accepted operation, wrap from DEPTH-1 to 0, and otherwise hold. In single-device mode no token pulse is sent.
- R11: `expOutN` is high while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low; mode and strap are sampled while it is low |
| expInN | input | 1 | Expansion input: tie low for single-device mode, or connect to the previous device's `expOutN` |
| flRtN | input | 1 | Strap in depth mode (low = starts with the tokens); retransmit in single-device mode |
| wrReq | input | 1 | Write request from the neighbouring core |
| rdReq | input | 1 | Read request from the neighbouring core |
| wrGrant | output | 1 | Write accepted this cycle |
| rdGrant | output | 1 | Read accepted this cycle |
| wrAddr | output | AW | Local write address |
| rdAddr | output | AW | Local read address |
| wrTokenHeld | output | 1 | Device owns write access |
| rdTokenHeld | output | 1 | Device owns read access |
| singleMode | output | 1 | Single-device mode was captured at reset |
| expOutN | output | 1 | Token pulse (depth mode) or half-full flag (single-device mode), active low |

## Verification
The two functions that can fall in the same cycle are the write-token hand-off and the read-token hand-off. This happens when a full device holds both tokens with both addresses at the last location. The bench builds that state on a standalone device: it fills the device, drains all but one word, hands the write token back through `expInN`, and refills to full. It then asserts both requests in one cycle. The result is judged by requiring two back-to-back low cycles on `expOutN` with both tokens released, followed by a return to high. A three-device ring also checks that tokens reach the next device one cycle after each pulse.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic wrStep;   // accepted write this cycle
    logic rdStep;   // accepted read this cycle
    logic rewind;   // single-device retransmit
  } chainStrobe_t;
endpackage

// File: rtl/fifo_chain_dp.sv
module fifo_chain_dp
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  chainStrobe_t  st,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrAtLast,
  output logic          rdAtLast,
  output logic          full,
  output logic          empty,
  output logic          halfFull
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          wroteAll;

  assign wrAddr   = wrPtr;
  assign rdAddr   = rdPtr;
  assign wrAtLast = (wrPtr == LAST);
  assign rdAtLast = (rdPtr == LAST);
  assign full     = (count == CAP);
  assign empty    = (count == '0);
  assign halfFull = (count > HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      wroteAll <= 1'b0;
    end else begin
      if (st.wrStep) begin
        wrPtr <= wrAtLast ? '0 : wrPtr + 1'b1;
        if (wrAtLast) wroteAll <= 1'b1;
      end
      if (st.rewind) begin
        rdPtr <= '0;
        count <= wroteAll ? CAP : CW'(wrPtr);
      end else begin
        if (st.rdStep) rdPtr <= rdAtLast ? '0 : rdPtr + 1'b1;
        count <= count + CW'(st.wrStep) - CW'(st.rdStep);
      end
    end
  end

  // R3: no write into a full store unless a read frees a slot
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (full && !st.rdStep) |-> !st.wrStep);
  // R3: no read from an empty store
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !st.rdStep);
  // R10: write address holds when nothing is written
  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !st.wrStep |=> $stable(wrPtr));
endmodule

// File: rtl/fifo_chain_ctl.sv
module fifo_chain_ctl
  import fifo_chain_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         expInN,
  input  logic         flRtN,
  input  logic         wrReq,
  input  logic         rdReq,
  input  logic         wrAtLast,
  input  logic         rdAtLast,
  input  logic         full,
  input  logic         empty,
  output chainStrobe_t st,
  output logic         wrGrant,
  output logic         rdGrant,
  output logic         wrTokenHeld,
  output logic         rdTokenHeld,
  output logic         singleMode,
  output logic         pulseOut
);
  logic modeSingle, wrTok, rdTok, expectWr, pendRd, pulseQ;
  logic rewind, wrHand, rdHand, inPulse, needRd;

  assign singleMode  = modeSingle;
  assign wrTokenHeld = modeSingle | wrTok;
  assign rdTokenHeld = modeSingle | rdTok;
  assign pulseOut    = pulseQ;

  always_comb begin
    rewind  = modeSingle & ~flRtN;
    rdGrant = rdReq & rdTokenHeld & ~empty & ~rewind;
    wrGrant = wrReq & wrTokenHeld & (~full | rdGrant) & ~rewind;
    wrHand  = wrGrant & wrAtLast & ~modeSingle;
    rdHand  = rdGrant & rdAtLast & ~modeSingle;
    inPulse = ~modeSingle & ~expInN;
    needRd  = pendRd | rdHand;
    st.wrStep = wrGrant;
    st.rdStep = rdGrant;
    st.rewind = rewind;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSingle <= ~expInN;
      wrTok      <= ~flRtN;
      rdTok      <= ~flRtN;
      expectWr   <= 1'b1;
      pendRd     <= 1'b0;
      pulseQ     <= 1'b0;
    end else begin
      // write hand-off wins the output; a colliding read waits one cycle
      pulseQ <= wrHand | needRd;
      pendRd <= needRd & wrHand;
      if (wrHand) wrTok <= 1'b0;
      else if (inPulse && expectWr) wrTok <= 1'b1;
      if (rdHand) rdTok <= 1'b0;
      else if (inPulse && !expectWr) rdTok <= 1'b1;
      if (inPulse) expectWr <= ~expectWr;
    end
  end

  // R4: losing the write token is announced at once
  assert_wr_release_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrTok) |-> pulseQ);
  // R6: colliding hand-offs give a pulse two cycles later as well
  assert_collision_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrHand && rdHand) |-> ##2 pulseQ);
  // R10: no token pulses in single-device mode
  assert_single_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    modeSingle |-> !pulseQ);
endmodule

// File: rtl/fifo_chain_ctrl.sv
module fifo_chain_ctrl
  import fifo_chain_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          expInN,
  input  logic          flRtN,
  input  logic          wrReq,
  input  logic          rdReq,
  output logic          wrGrant,
  output logic          rdGrant,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrTokenHeld,
  output logic          rdTokenHeld,
  output logic          singleMode,
  output logic          expOutN
);
  chainStrobe_t st;
  logic wrAtLast, rdAtLast, full, empty, halfFull, pulseOut;

  fifo_chain_ctl uCtl (
    .clk, .rstN, .expInN, .flRtN, .wrReq, .rdReq,
    .wrAtLast, .rdAtLast, .full, .empty,
    .st, .wrGrant, .rdGrant, .wrTokenHeld, .rdTokenHeld,
    .singleMode, .pulseOut
  );

  fifo_chain_dp #(.DEPTH(DEPTH)) uDp (
    .clk, .rstN, .st, .wrAddr, .rdAddr,
    .wrAtLast, .rdAtLast, .full, .empty, .halfFull
  );

  assign expOutN = ~rstN | (singleMode ? ~halfFull : ~pulseOut);
endmodule

// File: tb/tb_fifo_chain_ctrl.sv
module tb_fifo_chain_ctrl;
  localparam int D  = 8;
  localparam int RD = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, expInN = 1'b1, flRtN = 1'b1, wrReq = 1'b0, rdReq = 1'b0;
  logic wrGrant, rdGrant, wrTokenHeld, rdTokenHeld, singleMode, expOutN;
  logic [2:0] wrAddr, rdAddr;

  fifo_chain_ctrl #(.DEPTH(D)) dut (
    .clk, .rstN, .expInN, .flRtN, .wrReq, .rdReq, .wrGrant, .rdGrant,
    .wrAddr, .rdAddr, .wrTokenHeld, .rdTokenHeld, .singleMode, .expOutN
  );

  // three-device ring, device 0 strapped as first
  logic rWr = 1'b0, rRd = 1'b0;
  logic [2:0] rOutN, rWrG, rRdG, rWrT, rRdT, rSingle;
  logic [1:0] rWrA [3];
  logic [1:0] rRdA [3];

  for (genvar g = 0; g < 3; g++) begin : gRing
    fifo_chain_ctrl #(.DEPTH(RD)) ringDev (
      .clk, .rstN, .expInN(rOutN[(g + 2) % 3]), .flRtN(g != 0),
      .wrReq(rWr), .rdReq(rRd), .wrGrant(rWrG[g]), .rdGrant(rRdG[g]),
      .wrAddr(rWrA[g]), .rdAddr(rRdA[g]), .wrTokenHeld(rWrT[g]),
      .rdTokenHeld(rRdT[g]), .singleMode(rSingle[g]), .expOutN(rOutN[g])
    );
  end

  int nChecks = 0, nFails = 0;

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic doReset(input bit single, input bit first);
    @(negedge clk);
    rstN = 1'b0; expInN = single ? 1'b0 : 1'b1; flRtN = first ? 1'b0 : 1'b1;
    wrReq = 0; rdReq = 0; rWr = 0; rRd = 0;
    #1 check("R11 expOutN high in reset", expOutN, 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1; flRtN = 1'b1;
    #1;
  endtask

  task automatic doWrite(input int n);
    for (int i = 0; i < n; i++) begin wrReq = 1; @(negedge clk); end
    wrReq = 0; #1;
  endtask

  task automatic doRead(input int n);
    for (int i = 0; i < n; i++) begin rdReq = 1; @(negedge clk); end
    rdReq = 0; #1;
  endtask

  task automatic pulseIn();
    expInN = 0; @(negedge clk); expInN = 1; #1;
  endtask

  task automatic testSingle();
    doReset(1'b1, 1'b0);
    check("R1 singleMode", singleMode, 1);
    check("R1 single wr token", wrTokenHeld, 1);
    check("R1 single rd token", rdTokenHeld, 1);
    doWrite(4);
    check("R7 count 4 not half-full", expOutN, 1);
    doWrite(1);
    check("R7 count 5 half-full", expOutN, 0);
    check("R10 wrAddr after 5", wrAddr, 5);
    doRead(1);
    check("R7 count 4 after read", expOutN, 1);
    check("R10 rdAddr after 1", rdAddr, 1);
    flRtN = 0; wrReq = 1; #1;
    check("R8 write refused in retransmit", wrGrant, 0);
    @(negedge clk); flRtN = 1; wrReq = 0; #1;
    check("R8 rdAddr rewound", rdAddr, 0);
    check("R8 wrAddr kept", wrAddr, 5);
    check("R8 count restored to 5", expOutN, 0);
    doRead(5);
    check("R10 rdAddr after 5 reads", rdAddr, 5);
    rdReq = 1; #1;
    check("R3 read refused when empty", rdGrant, 0);
    rdReq = 0;
  endtask

  task automatic testFollower();
    doReset(1'b0, 1'b0);
    check("R1 depth mode", singleMode, 0);
    check("R2 follower wr token", wrTokenHeld, 0);
    check("R2 follower rd token", rdTokenHeld, 0);
    wrReq = 1; #1;
    check("R3 write refused without token", wrGrant, 0);
    wrReq = 0;
    pulseIn();
    check("R5 first pulse gives wr token", wrTokenHeld, 1);
    check("R5 first pulse no rd token", rdTokenHeld, 0);
    pulseIn();
    check("R5 second pulse gives rd token", rdTokenHeld, 1);
  endtask

  task automatic testCollision();
    doReset(1'b0, 1'b1);
    check("R2 first wr token", wrTokenHeld, 1);
    check("R2 first rd token", rdTokenHeld, 1);
    doWrite(7);
    check("R4 no pulse before last", expOutN, 1);
    doWrite(1);
    check("R4 wr pulse low", expOutN, 0);
    check("R4 wr token released", wrTokenHeld, 0);
    check("R4 wrAddr wrapped", wrAddr, 0);
    @(negedge clk); #1;
    check("R4 pulse one cycle", expOutN, 1);
    wrReq = 1; #1;
    check("R3 write refused after hand-off", wrGrant, 0);
    wrReq = 0;
    doRead(7);
    flRtN = 0; @(negedge clk); flRtN = 1; #1;
    check("R9 strap ignored after reset", rdAddr, 7);
    pulseIn();
    check("R5 wr token returned", wrTokenHeld, 1);
    doWrite(7);
    wrReq = 1; #1;
    check("R3 write refused when full", wrGrant, 0);
    rdReq = 1; #1;
    check("R3 write with read when full", wrGrant, 1);
    check("R3 read granted", rdGrant, 1);
    @(negedge clk); wrReq = 0; rdReq = 0; #1;
    check("R6 first pulse", expOutN, 0);
    check("R6 wr token gone", wrTokenHeld, 0);
    check("R6 rd token gone", rdTokenHeld, 0);
    @(negedge clk); #1;
    check("R6 second pulse", expOutN, 0);
    @(negedge clk); #1;
    check("R6 pulses end", expOutN, 1);
  endtask

  task automatic testRing();
    doReset(1'b0, 1'b0);
    check("R1 ring depth mode", rSingle, 0);
    check("R2 ring wr tokens", rWrT, 1);
    check("R2 ring rd tokens", rRdT, 1);
    for (int i = 0; i < RD; i++) begin rWr = 1; @(negedge clk); end
    #1;
    check("R4 ring0 pulse", rOutN, 3'b110);
    check("R4 ring wr token in flight", rWrT, 0);
    check("R3 no write grant in flight", rWrG, 0);
    @(negedge clk); #1;
    check("R5 ring1 has wr token", rWrT, 3'b010);
    check("R3 ring1 grants write", rWrG, 3'b010);
    for (int i = 0; i < RD; i++) @(negedge clk);
    rWr = 0; #1;
    check("R4 ring1 pulse", rOutN, 3'b101);
    for (int i = 0; i < RD; i++) begin rRd = 1; @(negedge clk); end
    rRd = 0; #1;
    check("R4 ring0 rd released", rRdT, 0);
    @(negedge clk); #1;
    check("R5 ring1 has rd token", rRdT, 3'b010);
    check("R5 ring2 has wr token", rWrT, 3'b100);
    rRd = 1; #1;
    check("R3 ring1 grants read", rRdG, 3'b010);
    check("R10 ring1 rdAddr", rRdA[1], 0);
    rRd = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  initial begin
    testSingle();
    testFollower();
    testCollision();
    testRing();
    summary();
  end
endmodule